// File: doc/BRIEF.md
# UART receive sampling clock generator

This block sits in front of an asynchronous serial receiver. It takes a timing tick that runs at 16 or 8 times the baud rate and watches the serial line for a start bit. From the tick it then makes a bit-sampling clock whose rising edges fall in the middle of every bit. The received bits are shifted into a byte, and the byte is handed out together with a one-cycle valid pulse.

All logic runs on one system clock. The timing clock arrives as `tclk_en`, a one-cycle enable that marks each falling edge of the timing clock. The serial input passes through a two-flop synchronizer before it is used. The start bit is checked twice: a short glitch, and a start bit that has gone high again by mid-bit, both send the block back to hunting for a start bit. Neither case raises an error and neither produces a byte.

Top module: `uart_rx_sampler`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `samp_clk` is 1, `rx_valid` is 0 and `rx_data` is 0.
- R2: With `div8` = 0 a bit lasts 16 ticks of `tclk_en`. With `div8` = 1 it lasts 8 ticks.
- R3: Ticks are counted from 1 after a low synchronized input is seen. `samp_clk` falls at tick 2 of each bit and rises at tick 8 of the bit (tick 4 when dividing by 8). That makes it low for 6 ticks and high for 10 (low 2, high 6 when dividing by 8), and the pattern repeats once per bit.
- R4: If the synchronized input is high again at tick 2 of the start bit, the event is treated as noise. `samp_clk` stays high, no byte is issued, and the block returns to start-bit detection.
- R5: If the input is high when the start bit is sampled at its mid-bit tick, reception is dropped. `samp_clk` stays high from then on and no byte or pulse is issued.
- R6: The frame is 1 start bit, 8 data bits sent LSB first and 1 stop bit. `rx_valid` pulses for one cycle, in the same cycle that the stop-bit sample makes `samp_clk` rise, and `rx_data` holds the assembled byte from that cycle onward.
- R7: After the stop bit has been sampled, `samp_clk` stays high until a new start bit is detected.
- R8: `div8` is taken only while the block is idle. A change of `div8` in the middle of a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tclk_en | input | 1 | One-cycle enable marking each falling edge of the timing clock |
| div8 | input | 1 | Divide select: 0 for divide by 16, 1 for divide by 8 |
| rxd | input | 1 | Serial input, idles high |
| samp_clk | output | 1 | Bit-sampling clock, rising edge at mid-bit |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when a byte is complete |

## Verification
Each result follows a `tclk_en` tick by exactly one register stage. The `samp_clk` level and the valid pulse both change on the clock edge that consumes the tick. The bench drives the serial line at the start of each tick window, which leaves time for the two synchronizer stages and the detection stage before the enable cycle. It then reads `samp_clk` on the falling edge right after the enable edge and compares it with the tick number expected from the requirements. Valid pulses are counted by a monitor on every clock edge. The glitch and short-start cases are checked by confirming that the pulse count has not moved and that `samp_clk` stays high over a long run of idle ticks.

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tclk_en,
  input  logic                 div8,
  input  logic                 rxd,
  output logic                 samp_clk,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid
);
  localparam int BW   = $clog2(DATA_BITS + 2);
  localparam int PW   = 5;
  localparam logic [BW-1:0] STOP = BW'(DATA_BITS + 1);

  logic s1, s2, run, mode_q;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [DATA_BITS-1:0] shreg;

  wire [PW-1:0] ph_last = mode_q ? PW'(8) : PW'(16);
  wire [PW-1:0] ph_mid  = mode_q ? PW'(4) : PW'(8);
  wire [PW-1:0] ph_n    = (ph == ph_last) ? PW'(1) : ph + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      run <= 1'b0;
      mode_q <= 1'b0;
      samp_clk <= 1'b1;
      rx_valid <= 1'b0;
      rx_data <= '0;
      ph <= '0;
      bitn <= '0;
      shreg <= '0;
    end else begin
      s1 <= rxd;
      s2 <= s1;
      rx_valid <= 1'b0;
      if (!run) begin
        mode_q <= div8;
        samp_clk <= 1'b1;
        if (!s2) begin
          run <= 1'b1;
          ph <= '0;
          bitn <= '0;
        end
      end else if (tclk_en) begin
        ph <= ph_n;
        if (ph_n == PW'(2)) begin
          if (bitn == '0 && s2) run <= 1'b0;
          else samp_clk <= 1'b0;
        end else if (ph_n == ph_mid) begin
          samp_clk <= 1'b1;
          if (bitn == '0) begin
            if (s2) run <= 1'b0;
            else bitn <= BW'(1);
          end else if (bitn == STOP) begin
            run <= 1'b0;
            rx_valid <= 1'b1;
            rx_data <= shreg;
          end else begin
            shreg <= {s2, shreg[DATA_BITS-1:1]};
            bitn <= bitn + BW'(1);
          end
        end
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run)) |-> samp_clk);  // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);  // R6
  AST_VALID_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $rose(samp_clk));  // R6
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(samp_clk) |-> $past(tclk_en));  // R3
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(samp_clk) |-> $past(tclk_en));  // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run)) |-> $stable(mode_q));  // R8
endmodule

// File: tb/uart_rx_sampler_bench.sv
module uart_rx_sampler_bench;
  logic clk = 1'b0, rst = 1'b1, tclk_en = 1'b0, div8 = 1'b0, rxd = 1'b1;
  logic samp_clk, rx_valid;
  logic [7:0] rx_data;
  int checks = 0, errors = 0, vcount = 0, cycles = 0;
  logic [7:0] last_data = '0;

  always #10 clk = ~clk;

  uart_rx_sampler u_uart_rx_sampler (
    .clk(clk), .rst(rst), .tclk_en(tclk_en), .div8(div8), .rxd(rxd),
    .samp_clk(samp_clk), .rx_data(rx_data), .rx_valid(rx_valid));

  always @(posedge clk) begin
    cycles++;
    if (!rst && rx_valid) begin
      vcount++;
      last_data = rx_data;
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    repeat (7) @(negedge clk);
    tclk_en = 1'b1;
    @(negedge clk);
    tclk_en = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic m, input logic flip);
    int n = m ? 8 : 16;
    int mid = m ? 4 : 8;
    int v0 = vcount;
    int bad = 0;
    div8 = m;
    for (int bi = 0; bi < 10; bi++) begin
      rxd = (bi == 0) ? 1'b0 : (bi == 9) ? 1'b1 : b[bi-1];
      for (int t = 1; t <= n; t++) begin
        if (flip && bi == 4 && t == 1) div8 = ~m;
        tick();
        if (bi == 9 && t > mid) begin
          if (samp_clk !== 1'b1) bad++;
        end else if (samp_clk !== ((t >= 2 && t < mid) ? 1'b0 : 1'b1)) bad++;
      end
    end
    div8 = m;
    chk(flip ? "R8 sampling pattern with mode flip" : "R2/R3 sampling pattern", bad, 0);
    chk("R6 one valid pulse", vcount - v0, 1);
    chk("R6 byte LSB first", int'(last_data), int'(b));
    bad = 0;
    for (int t = 0; t < 24; t++) begin
      tick();
      if (samp_clk !== 1'b1) bad++;
    end
    chk("R7 high after stop", bad, 0);
  endtask

  task automatic glitch();
    int v0 = vcount;
    int bad = 0;
    div8 = 1'b0;
    rxd = 1'b0;
    tick();
    rxd = 1'b1;
    for (int t = 0; t < 40; t++) begin
      tick();
      if (samp_clk !== 1'b1) bad++;
    end
    chk("R4 glitch keeps samp_clk high", bad, 0);
    chk("R4 glitch gives no byte", vcount - v0, 0);
  endtask

  task automatic short_start();
    int v0 = vcount;
    int bad = 0;
    div8 = 1'b0;
    rxd = 1'b0;
    tick();
    chk("R5 high at tick 1", int'(samp_clk), 1);
    tick();
    chk("R5 low at tick 2", int'(samp_clk), 0);
    tick();
    tick();
    rxd = 1'b1;
    for (int t = 5; t <= 8; t++) tick();
    chk("R5 high at mid-bit abort", int'(samp_clk), 1);
    for (int t = 0; t < 200; t++) begin
      tick();
      if (samp_clk !== 1'b1) bad++;
    end
    chk("R5 stays high after abort", bad, 0);
    chk("R5 no byte after abort", vcount - v0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 samp_clk in reset", int'(samp_clk), 1);
    chk("R1 rx_valid in reset", int'(rx_valid), 0);
    chk("R1 rx_data in reset", int'(rx_data), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 samp_clk after reset", int'(samp_clk), 1);
    repeat (2) tick();
    send_frame(8'hA5, 1'b0, 1'b0);
    send_frame(8'h3C, 1'b1, 1'b0);
    glitch();
    short_start();
    send_frame(8'h81, 1'b0, 1'b0);
    send_frame(8'h6E, 1'b0, 1'b1);
    send_frame(8'hF0, 1'b1, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule